// File: doc/BRIEF.md
# Canonic Signed-Digit Recoder

This block turns an unsigned binary constant of `WIDTH` bits into its canonic signed-digit form. In that form every digit is -1, 0 or +1, no two nonzero digits are neighbours, and the number of nonzero digits is the smallest that any signed-digit form of the value can have. A typical use is planning a constant multiplier: each nonzero digit costs one adder or subtractor, so the recoded form needs the fewest of them.

The recoder works through the input one bit per clock, starting at the least significant bit. A carry register records whether a run of ones is still open. When a run of two or more ones ends, a +1 appears just above it and a -1 appears at its lowest bit. Carries from neighbouring runs merge on their own, so the no-neighbour rule also holds across merged runs. The result has `WIDTH+1` digit positions, because a run that reaches the top input bit adds one digit above it. A caller raises `start_i` with the value while the block is idle. After `WIDTH+1` steps, `done_o` pulses for one cycle, and the digits and the nonzero count are then valid.

Top module: `csd_recoder`

## Requirements
- R1: Each digit position i has two output bits. `digit_nz_o[i]`=1 means the digit is nonzero. `digit_neg_o[i]`=1 means the digit is -1. A zero digit never has its sign bit set.
- R2: When `done_o` is high, the sum over i of digit(i)·2^i equals the input value taken at acceptance.
- R3: When `done_o` is high, no two adjacent digit positions are both nonzero.
- R4: When `done_o` is high, `weight_o` equals the number of nonzero digits. That number is the minimum for the value: the popcount of ((3·x) XOR x) shifted right by one.
- R5: A run of ones ending at the top input bit yields +1 at position `WIDTH`. Digit `WIDTH` is never -1.
- R6: `start_i` is accepted only when the block is idle, meaning `busy_o` and `done_o` are both low. A `start_i` pulse while busy has no effect on the result.
- R7: `busy_o` rises in the cycle after acceptance and stays high for `WIDTH+1` cycles. `done_o` is high for exactly one cycle, starting `WIDTH+1` cycles after the acceptance edge.
- R8: The digits and `weight_o` hold their values from `done_o` until the next start is accepted.
- R9: While reset is asserted and right after it, `busy_o`, `done_o`, all digit bits and `weight_o` are zero.
- R10: An isolated run of ones in bits j..k, with k>j, recodes to +1 at position k+1 and -1 at position j. A single isolated one stays +1 at its own position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to recode `value_i` (sampled only when idle) |
| value_i | input | WIDTH | Unsigned constant to recode |
| busy_o | output | 1 | Recoding in progress |
| done_o | output | 1 | One-cycle pulse when the result becomes valid |
| digit_nz_o | output | WIDTH+1 | Nonzero flag for each digit position |
| digit_neg_o | output | WIDTH+1 | Sign flag for each digit position (1 means -1) |
| weight_o | output | $clog2(WIDTH+2) | Count of nonzero digits |

## Verification
Two events can fall in the same cycle: a new `start_i` request and an unfinished recode that is still consuming bits. The bench provokes this by raising `start_i` with the complemented value in the middle of a run. It then judges the outcome by comparing the final digits with the expected form of the original value, not the intruding one. A second collision is the last digit step landing on the same edge as the final carry, for all-ones inputs and runs that touch the top bit. The exhaustive sweep covers these cases, and the check there is that position `WIDTH` carries +1 and the pulse timing is unchanged.

// File: rtl/csd_pkg.sv
package csd_pkg;
  typedef struct packed {
    logic nz;
    logic neg;
  } csd_digit_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } csd_state_e;
endpackage

// File: rtl/csd_step.sv
module csd_step
  import csd_pkg::*;
(
  input  logic       bit_cur_i,
  input  logic       bit_next_i,
  input  logic       carry_i,
  output csd_digit_t digit_o,
  output logic       carry_o
);
  logic sum_odd, sum_two;
  assign sum_odd = bit_cur_i ^ carry_i;
  assign sum_two = bit_cur_i & carry_i;

  always_comb begin
    digit_o = '0;
    carry_o = 1'b0;
    if (sum_two) begin
      carry_o = 1'b1;
    end else if (sum_odd) begin
      digit_o.nz = 1'b1;
      if (bit_next_i) begin
        // run continues: emit -1, push carry upward
        digit_o.neg = 1'b1;
        carry_o     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/csd_ctrl.sv
module csd_ctrl
  import csd_pkg::*;
#(
  parameter int unsigned STEPS = 9,
  localparam int unsigned CW   = $clog2(STEPS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  csd_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_o  = 1'b1;
        cnt_d   = '0;
        state_d = ST_RUN;
      end
      ST_RUN: begin
        step_o = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/csd_accum.sv
module csd_accum
  import csd_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned ND   = WIDTH + 1,
  localparam int unsigned CNTW = $clog2(WIDTH + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] value_i,
  output logic [ND-1:0]    nz_o,
  output logic [ND-1:0]    neg_o,
  output logic [CNTW-1:0]  weight_o
);
  // one spare zero bit above the value supplies the look-ahead bit
  logic [WIDTH:0]  src_q;
  logic            carry_q, carry_d;
  logic [ND-1:0]   nz_q, neg_q;
  logic [CNTW-1:0] weight_q;
  csd_digit_t      digit;

  csd_step u_step (
    .bit_cur_i (src_q[0]),
    .bit_next_i(src_q[1]),
    .carry_i   (carry_q),
    .digit_o   (digit),
    .carry_o   (carry_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      carry_q  <= 1'b0;
      nz_q     <= '0;
      neg_q    <= '0;
      weight_q <= '0;
    end else if (load_i) begin
      src_q    <= {1'b0, value_i};
      carry_q  <= 1'b0;
      nz_q     <= '0;
      neg_q    <= '0;
      weight_q <= '0;
    end else if (step_i) begin
      // new digit enters at the top; after ND steps digit 0 sits at bit 0
      src_q    <= src_q >> 1;
      carry_q  <= carry_d;
      nz_q     <= {digit.nz, nz_q[ND-1:1]};
      neg_q    <= {digit.neg, neg_q[ND-1:1]};
      weight_q <= weight_q + CNTW'(digit.nz);
    end
  end

  assign nz_o     = nz_q;
  assign neg_o    = neg_q;
  assign weight_o = weight_q;
endmodule

// File: rtl/csd_recoder.sv
module csd_recoder
  import csd_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned ND   = WIDTH + 1,
  localparam int unsigned CNTW = $clog2(WIDTH + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] value_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [ND-1:0]    digit_nz_o,
  output logic [ND-1:0]    digit_neg_o,
  output logic [CNTW-1:0]  weight_o
);
  logic load, step;

  csd_ctrl #(.STEPS(ND)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  csd_accum #(.WIDTH(WIDTH)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .value_i (value_i),
    .nz_o    (digit_nz_o),
    .neg_o   (digit_neg_o),
    .weight_o(weight_o)
  );
endmodule

// File: rtl/csd_recoder_chk.sv
module csd_recoder_chk #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned ND   = WIDTH + 1,
  localparam int unsigned CNTW = $clog2(WIDTH + 2)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [ND-1:0]   digit_nz_o,
  input logic [ND-1:0]   digit_neg_o,
  input logic [CNTW-1:0] weight_o
);
  logic accept;
  assign accept = start_i && !busy_o && !done_o;

  assert_zero_unsigned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_neg_o & ~digit_nz_o) == '0);

  for (genvar i = 0; i < ND - 1; i++) begin : g_adj
    assert_no_adjacent_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !(digit_nz_o[i] && digit_nz_o[i+1]));
  end

  assert_weight_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (32'(weight_o) == $countones(digit_nz_o)));

  assert_top_positive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !digit_neg_o[ND-1]);

  assert_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !accept) |=> ($stable(digit_nz_o) && $stable(digit_neg_o) && $stable(weight_o)));
endmodule

bind csd_recoder csd_recoder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .digit_nz_o (digit_nz_o),
  .digit_neg_o(digit_neg_o),
  .weight_o   (weight_o)
);

// File: tb/csd_recoder_tb_top.sv
module csd_recoder_tb_top;
  localparam int unsigned WIDTH = 8;
  localparam int unsigned ND    = WIDTH + 1;
  localparam int unsigned CNTW  = $clog2(WIDTH + 2);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [WIDTH-1:0] value_i = '0;
  logic busy_o, done_o;
  logic [ND-1:0] digit_nz_o, digit_neg_o;
  logic [CNTW-1:0] weight_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  csd_recoder #(.WIDTH(WIDTH)) dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // minimal-weight form: with h = 3x, +1 where h has a bit x lacks, -1 the reverse
  function automatic logic [ND-1:0] exp_pos(input logic [WIDTH-1:0] v);
    logic [WIDTH+1:0] x, h;
    x = {2'b00, v};
    h = x * 3;
    return ND'((h & ~x) >> 1);
  endfunction

  function automatic logic [ND-1:0] exp_neg(input logic [WIDTH-1:0] v);
    logic [WIDTH+1:0] x, h;
    x = {2'b00, v};
    h = x * 3;
    return ND'((~h & x) >> 1);
  endfunction

  function automatic longint digit_sum(input logic [ND-1:0] nz, input logic [ND-1:0] ng);
    longint s = 0;
    for (int i = 0; i < ND; i++)
      if (nz[i]) s = ng[i] ? s - (longint'(1) << i) : s + (longint'(1) << i);
    return s;
  endfunction

  task automatic run(input logic [WIDTH-1:0] v, input bit intrude);
    logic [ND-1:0] ep, en, nz_s, ng_s;
    logic [CNTW-1:0] w_s;
    bit adj;
    ep = exp_pos(v);
    en = exp_neg(v);
    @(negedge clk_i);
    start_i = 1'b1;
    value_i = v;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o === 1'b1 && done_o === 1'b0, "R7", "busy after accept", busy_o, 1);
    for (int k = 1; k <= ND; k++) begin
      if (intrude && k == 3) begin
        start_i = 1'b1;
        value_i = ~v;
      end
      @(posedge clk_i);
      @(negedge clk_i);
      start_i = 1'b0;
      if (k < ND) begin
        if (done_o !== 1'b0 || busy_o !== 1'b1)
          check(1'b0, "R7", "early done/busy drop", {busy_o, done_o}, 2'b10);
      end else begin
        check(done_o === 1'b1 && busy_o === 1'b0, "R7", "done timing",
              {busy_o, done_o}, 2'b01);
      end
    end
    nz_s = digit_nz_o;
    ng_s = digit_neg_o;
    w_s  = weight_o;
    check(nz_s == (ep | en) && ng_s == en, intrude ? "R6" : "R4", "digit pattern",
          {nz_s, ng_s}, {ep | en, en});
    check(digit_sum(nz_s, ng_s) == longint'(v), "R2", "digit sum",
          digit_sum(nz_s, ng_s), longint'(v));
    adj = |(nz_s[ND-1:1] & nz_s[ND-2:0]);
    check(!adj, "R3", "adjacent nonzero", nz_s, ep | en);
    check((ng_s & ~nz_s) == '0, "R1", "sign on zero digit", ng_s, en);
    check(32'(w_s) == $countones(ep | en), "R4", "weight", w_s, $countones(ep | en));
    check(!ng_s[ND-1], "R5", "top digit negative", ng_s[ND-1], 0);
    @(posedge clk_i);
    @(negedge clk_i);
    check(done_o === 1'b0 && digit_nz_o == nz_s && digit_neg_o == ng_s && weight_o == w_s,
          "R8", "hold after done", {digit_nz_o, digit_neg_o}, {nz_s, ng_s});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    check(busy_o === 1'b0 && done_o === 1'b0 && digit_nz_o == '0 &&
          digit_neg_o == '0 && weight_o == '0, "R9", "in reset",
          {busy_o, done_o, digit_nz_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o === 1'b0 && done_o === 1'b0 && digit_nz_o == '0 && weight_o == '0,
          "R9", "after reset", {busy_o, done_o, digit_nz_o}, 0);

    // R10 directed: 0b0111 -> +1@3, -1@0; single one stays put
    run(8'h07, 1'b0);
    check(digit_nz_o == 9'h009 && digit_neg_o == 9'h001, "R10", "run 0..2",
          {digit_nz_o, digit_neg_o}, {9'h009, 9'h001});
    run(8'h10, 1'b0);
    check(digit_nz_o == 9'h010 && digit_neg_o == 9'h000, "R10", "single one",
          {digit_nz_o, digit_neg_o}, {9'h010, 9'h000});
    // R5 directed: all ones -> +1@8, -1@0
    run(8'hFF, 1'b0);
    check(digit_nz_o == 9'h101 && digit_neg_o == 9'h001, "R5", "all ones",
          {digit_nz_o, digit_neg_o}, {9'h101, 9'h001});
    // R6 directed: start during busy is ignored
    run(8'h5B, 1'b1);

    for (int v = 0; v < (1 << WIDTH); v++) run(WIDTH'(v), 1'b0);
    for (int r = 0; r < 150; r++) run(WIDTH'($urandom), ($urandom % 3) == 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule